// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block gathers eight edge-sensitive interrupt request lines into one interrupt line toward a processor. When the processor acknowledges, the block hands back an 8-bit vector. Software programs it through an 8-bit write port that has a one-bit address. A short initialization sequence comes first. It sets the upper vector bits, the single-or-cascade selection and the end-of-interrupt style. After that, operation commands set the mask, retire serviced levels, rotate priorities and choose which status register a read returns.

The controller keeps a request register, an in-service register and a mask register. Priority is circular and starts with input 0 as the highest. Rotation commands move the lowest-priority position, so a level that has just been serviced can drop to the back of the order. Only single (non-cascaded) operation is supported. In cascade mode the extra initialization word is accepted and then discarded. All bus accesses are single-cycle strobes on a synchronous clock.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, irq and vector are 0, the mask register reads 0, and the block ignores request edges until an initialization sequence completes.
- R2: A write with a0=0 and wdata bit 4 = 1 starts initialization from any state. It clears the mask, request and in-service registers, resets the priority order to fixed (input 0 highest, input 7 lowest), selects the request register for a0=0 reads, and selects normal end-of-interrupt.
- R3: In the first initialization word, bit 1 = 1 selects single mode and bit 1 = 0 selects cascade mode; bit 0 = 1 means a fourth word follows. The next a0=1 write stores bits 7..3 as the vector base. In cascade mode one further a0=1 write is accepted and discarded. If a fourth word is expected, it is the next a0=1 write. The controller is ready once the last expected word has been written.
- R4: A rising edge on req_in[i] sets request bit i. An input held high does not request again.
- R5: After initialization, a write with a0=1 loads the mask from wdata. A masked request does not raise irq but stays visible in the request register.
- R6: irq is registered and goes high when the highest-priority unmasked request outranks every in-service level.
- R7: An ack strobe updates vector at the next clock edge to {base, level}, where level is the highest-priority unmasked request. That request bit moves into the in-service register. If no unmasked request is pending, the vector's level field is 7 and no register changes.
- R8: A write with a0=0, bits 4 and 3 = 0, and bits 7..5 = 001 clears the highest-priority in-service bit. Bits 7..5 = 011 clears the in-service bit at the level given by bits 2..0.
- R9: With fourth-word bit 1 = 1 (automatic end-of-interrupt), an acknowledge sets no in-service bit.
- R10: Bits 7..5 = 101 perform an R8 non-specific clear and make the cleared level the lowest priority. Bits 7..5 = 111 perform an R8 specific clear and make the named level the lowest. Bits 7..5 = 110 only make the level in bits 2..0 the lowest.
- R11: A write with a0=0, bit 4 = 0, bit 3 = 1 and bit 1 = 1 selects the a0=0 read source: bit 0 = 0 selects the request register, bit 0 = 1 the in-service register. A read with a0=1 returns the mask. Read data appears at the clock edge that samples the read strobe.
- R12: A request of lower priority than a level in service does not raise irq. A request of higher priority does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select for bus accesses |
| rd | input | 1 | Read strobe, qualified by cs |
| wr | input | 1 | Write strobe, qualified by cs |
| a0 | input | 1 | Register address bit |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| req_in | input | NUM_IN | Edge-sensitive interrupt request lines |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq | output | 1 | Interrupt request to the processor |
| vector | output | DATA_W | Vector returned on acknowledge |

## Verification
The bench builds the block with its default eight request lines and an 8-bit bus, so the three-bit level field fills the low bits of the vector exactly. At this size, every rotated priority order can be set from the bus. Nesting, masking and spurious acknowledges can all be reached with a handful of lines. The bench uses two vector bases and both initialization paths, single without automatic end-of-interrupt and cascade with it. This shows that the base field and the optional extra word are handled separately.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IRQ_LINES = 8;
  localparam int unsigned LVL_W     = $clog2(IRQ_LINES);

  typedef enum logic [2:0] {
    ST_WAIT_ICW1,
    ST_WAIT_ICW2,
    ST_WAIT_ICW3,
    ST_WAIT_ICW4,
    ST_READY
  } init_st_t;

  typedef struct packed {
    logic             eoi_ns;
    logic             eoi_sp;
    logic             rotate;
    logic             set_prio;
    logic [LVL_W-1:0] lvl;
  } ocw2_cmd_t;
endpackage

// File: rtl/irqc_cmd_decode.sv
module irqc_cmd_decode
  import irqc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_IN = 8,
  parameter int unsigned BASE_W = DATA_W - LVL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              a0,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              init_clr,
  output logic [BASE_W-1:0] base,
  output logic              aeoi,
  output logic              sel_isr,
  output logic [NUM_IN-1:0] imr,
  output ocw2_cmd_t         cmd
);
  init_st_t st;
  logic     need_w4;
  logic     cascade;

  assign ready = (st == ST_READY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_WAIT_ICW1;
      base     <= '0;
      aeoi     <= 1'b0;
      sel_isr  <= 1'b0;
      imr      <= '0;
      need_w4  <= 1'b0;
      cascade  <= 1'b0;
      init_clr <= 1'b0;
      cmd      <= '0;
    end else begin
      init_clr <= 1'b0;
      cmd      <= '0;
      if (wr_stb) begin
        if (!a0 && wdata[4]) begin
          st       <= ST_WAIT_ICW2;
          imr      <= '0;
          sel_isr  <= 1'b0;
          aeoi     <= 1'b0;
          need_w4  <= wdata[0];
          cascade  <= !wdata[1];
          init_clr <= 1'b1;
        end else begin
          case (st)
            ST_WAIT_ICW2: if (a0) begin
              base <= wdata[DATA_W-1:LVL_W];
              if (cascade)      st <= ST_WAIT_ICW3;
              else if (need_w4) st <= ST_WAIT_ICW4;
              else              st <= ST_READY;
            end
            ST_WAIT_ICW3: if (a0) st <= need_w4 ? ST_WAIT_ICW4 : ST_READY;
            ST_WAIT_ICW4: if (a0) begin
              aeoi <= wdata[1];
              st   <= ST_READY;
            end
            ST_READY: begin
              if (a0) begin
                imr <= wdata[NUM_IN-1:0];
              end else if (wdata[3]) begin
                if (wdata[1]) sel_isr <= wdata[0];
              end else begin
                cmd.lvl <= wdata[LVL_W-1:0];
                case (wdata[7:5])
                  3'b001: cmd.eoi_ns <= 1'b1;
                  3'b011: cmd.eoi_sp <= 1'b1;
                  3'b101: begin cmd.eoi_ns <= 1'b1; cmd.rotate <= 1'b1; end
                  3'b111: begin cmd.eoi_sp <= 1'b1; cmd.rotate <= 1'b1; end
                  3'b110: cmd.set_prio <= 1'b1;
                  default: ;
                endcase
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_ICW1_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !a0 && wdata[4]) |=> (imr == '0 && !ready && !aeoi)); // R2
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int unsigned NUM_IN = 8,
  parameter int unsigned LVL_W  = $clog2(NUM_IN)
) (
  input  logic [NUM_IN-1:0] vec,
  input  logic [LVL_W-1:0]  lowest,
  output logic              hit,
  output logic [LVL_W-1:0]  lvl
);
  logic [NUM_IN-1:0] rot;
  logic [LVL_W-1:0]  src [NUM_IN];

  // rot[0] is the highest-priority position, one past the lowest level
  for (genvar k = 0; k < NUM_IN; k++) begin : g_rot
    assign src[k] = lowest + LVL_W'(k + 1);
    assign rot[k] = vec[src[k]];
  end

  always_comb begin
    hit = |rot;
    lvl = lowest;
    for (int k = NUM_IN - 1; k >= 0; k--) begin
      if (rot[k]) lvl = src[k];
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IN = IRQ_LINES,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              a0,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_IN-1:0] req_in,
  input  logic              ack,
  output logic              irq,
  output logic [DATA_W-1:0] vector
);
  localparam int unsigned BASE_W = DATA_W - LVL_W;

  logic              ready, init_clr, aeoi, sel_isr;
  logic [BASE_W-1:0] base;
  logic [NUM_IN-1:0] imr, irr, isr, req_q, rise, pend;
  logic [NUM_IN-1:0] irr_n, isr_n;
  logic [LVL_W-1:0]  lowest, lowest_n;
  ocw2_cmd_t         cmd;
  logic              pend_hit, isr_hit, all_hit;
  logic [LVL_W-1:0]  pend_lvl, isr_lvl, all_lvl;
  logic              wr_stb, rd_stb, ack_ok, ack_hit;

  assign wr_stb  = cs & wr;
  assign rd_stb  = cs & rd;
  assign rise    = req_in & ~req_q;
  assign pend    = irr & ~imr;
  assign ack_ok  = ack & ready;
  assign ack_hit = ack_ok & pend_hit;

  irqc_cmd_decode #(.DATA_W(DATA_W), .NUM_IN(NUM_IN), .BASE_W(BASE_W)) u_dec (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .a0(a0), .wdata(wdata),
    .ready(ready), .init_clr(init_clr), .base(base), .aeoi(aeoi),
    .sel_isr(sel_isr), .imr(imr), .cmd(cmd)
  );

  irqc_prio_pick #(.NUM_IN(NUM_IN), .LVL_W(LVL_W)) u_pick_pend (
    .vec(pend), .lowest(lowest), .hit(pend_hit), .lvl(pend_lvl));
  irqc_prio_pick #(.NUM_IN(NUM_IN), .LVL_W(LVL_W)) u_pick_isr (
    .vec(isr), .lowest(lowest), .hit(isr_hit), .lvl(isr_lvl));
  irqc_prio_pick #(.NUM_IN(NUM_IN), .LVL_W(LVL_W)) u_pick_all (
    .vec(pend | isr), .lowest(lowest), .hit(all_hit), .lvl(all_lvl));

  always_comb begin
    irr_n    = irr;
    isr_n    = isr;
    lowest_n = lowest;
    if (cmd.eoi_ns && isr_hit) begin
      isr_n[isr_lvl] = 1'b0;
      if (cmd.rotate) lowest_n = isr_lvl;
    end
    if (cmd.eoi_sp) begin
      isr_n[cmd.lvl] = 1'b0;
      if (cmd.rotate) lowest_n = cmd.lvl;
    end
    if (cmd.set_prio) lowest_n = cmd.lvl;
    if (ack_hit) begin
      irr_n[pend_lvl] = 1'b0;
      if (!aeoi) isr_n[pend_lvl] = 1'b1;
    end
    irr_n = irr_n | rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      irr    <= '0;
      isr    <= '0;
      lowest <= '1;
      irq    <= 1'b0;
      vector <= '0;
      rdata  <= '0;
    end else begin
      req_q <= req_in;
      if (init_clr) begin
        irr    <= '0;
        isr    <= '0;
        lowest <= '1;
      end else begin
        irr    <= ready ? irr_n : '0;
        isr    <= isr_n;
        lowest <= lowest_n;
      end
      irq <= ready && all_hit && pend[all_lvl] && !isr[all_lvl];
      if (ack_ok) vector <= {base, ack_hit ? pend_lvl : {LVL_W{1'b1}}};
      if (rd_stb) rdata <= a0 ? DATA_W'(imr) : DATA_W'(sel_isr ? isr : irr);
    end
  end

  AST_IRQ_IDLE_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    $past(!ready) |-> !irq); // R1
  AST_AEOI_ISR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    aeoi |-> (isr == '0)); // R9
  AST_ACK_TO_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (ack_hit && !aeoi && !cmd.eoi_ns && !cmd.eoi_sp) |=> isr[$past(pend_lvl)]); // R7
  AST_VECTOR_BASE: assert property (@(posedge clk) disable iff (rst)
    ack_ok |=> (vector[DATA_W-1:LVL_W] == $past(base))); // R3
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 0, rd = 0, wr = 0, a0 = 0, ack = 0;
  logic [7:0] wdata = 0, req_in = 0;
  logic [7:0] rdata, vector;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    string      tag;
    bit         is_vec;
    logic [7:0] val;
  } exp_t;
  exp_t exp_q[$];

  logic rd_seen = 0, ack_seen = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .a0(a0),
    .wdata(wdata), .rdata(rdata), .req_in(req_in), .ack(ack),
    .irq(irq), .vector(vector)
  );

  // monitor: note which strobes were sampled, compare on the following falling edge
  always @(posedge clk) begin
    rd_seen  <= cs & rd;
    ack_seen <= ack;
  end

  always @(negedge clk) begin
    exp_t       e;
    logic [7:0] act;
    if (rd_seen || ack_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty: actual rdata=%02h vector=%02h expected none", rdata, vector);
      end else begin
        e   = exp_q.pop_front();
        act = e.is_vec ? vector : rdata;
        if (act !== e.val) begin
          fails++;
          $display("FAIL %s actual=%02h expected=%02h", e.tag, act, e.val);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic addr, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; a0 = addr; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
    idle(2);
  endtask

  task automatic bus_rd(input logic addr, input logic [7:0] expv, input string tag);
    exp_t e;
    @(negedge clk);
    cs = 1; rd = 1; a0 = addr;
    e.tag = tag; e.is_vec = 0; e.val = expv;
    exp_q.push_back(e);
    @(negedge clk);
    cs = 0; rd = 0;
    idle(1);
  endtask

  task automatic do_ack(input logic [7:0] expv, input string tag);
    exp_t e;
    @(negedge clk);
    ack = 1;
    e.tag = tag; e.is_vec = 1; e.val = expv;
    exp_q.push_back(e);
    @(negedge clk);
    ack = 0;
    idle(2);
  endtask

  task automatic set_req(input logic [7:0] v);
    @(negedge clk);
    req_in = v;
    idle(3);
  endtask

  task automatic chk_irq(input logic expv, input string tag);
    checks++;
    if (irq !== expv) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, expv);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    chk_irq(0, "R1 irq in reset");
    rst = 0;
    idle(2);
    chk_irq(0, "R1 irq after reset");
    checks++;
    if (vector !== 8'h00) begin
      fails++;
      $display("FAIL R1 vector actual=%02h expected=00", vector);
    end
    bus_rd(1, 8'h00, "R1 mask after reset");
    set_req(8'h01);
    chk_irq(0, "R1 request ignored before init");
    set_req(8'h00);

    // single mode, fourth word follows, base 0x40, normal end-of-interrupt
    bus_wr(0, 8'h13);
    bus_wr(1, 8'h40);
    bus_wr(1, 8'h01);
    bus_rd(0, 8'h00, "R2 request register selected, empty");
    bus_rd(1, 8'h00, "R2 mask clear");

    set_req(8'h08);
    chk_irq(1, "R4 R6 edge on input 3 raises irq");
    bus_rd(0, 8'h08, "R11 request register readback");
    do_ack(8'h43, "R7 vector for input 3");
    idle(1);
    chk_irq(0, "R6 irq drops after ack");
    bus_wr(0, 8'h0B);
    bus_rd(0, 8'h08, "R11 in-service readback");

    set_req(8'h28);
    chk_irq(0, "R12 lower level blocked by in-service 3");
    set_req(8'h2A);
    chk_irq(1, "R12 higher level 1 nests");
    do_ack(8'h41, "R7 vector for input 1");
    idle(1);
    chk_irq(0, "R12 level 5 still blocked");
    bus_rd(0, 8'h0A, "R7 in-service holds 1 and 3");

    bus_wr(0, 8'h20);
    bus_rd(0, 8'h08, "R8 non-specific clears level 1");
    chk_irq(0, "R12 level 5 blocked by 3");
    bus_wr(0, 8'h63);
    bus_rd(0, 8'h00, "R8 specific clears level 3");
    chk_irq(1, "R12 level 5 released");
    do_ack(8'h45, "R7 vector for input 5");
    bus_wr(0, 8'h20);
    bus_rd(0, 8'h00, "R8 in-service empty");

    idle(2);
    chk_irq(0, "R4 held inputs do not re-request");
    bus_wr(0, 8'h0A);
    bus_rd(0, 8'h00, "R4 request register empty with inputs held");

    set_req(8'h00);
    bus_wr(1, 8'h04);
    set_req(8'h04);
    chk_irq(0, "R5 masked input 2 quiet");
    bus_rd(0, 8'h04, "R5 masked request stays pending");
    bus_rd(1, 8'h04, "R11 mask readback");
    bus_wr(1, 8'h00);
    chk_irq(1, "R5 unmask releases input 2");
    do_ack(8'h42, "R7 vector for input 2");
    bus_wr(0, 8'h20);

    set_req(8'h00);
    bus_wr(0, 8'hC2);
    set_req(8'h11);
    chk_irq(1, "R10 pending 0 and 4");
    do_ack(8'h44, "R10 lowest=2 puts 4 ahead of 0");
    bus_wr(0, 8'hA0);
    set_req(8'h19);
    do_ack(8'h40, "R10 rotate on non-specific makes 4 lowest, 0 ahead of 3");
    bus_wr(0, 8'hE0);
    set_req(8'h1B);
    do_ack(8'h41, "R10 specific rotate, 1 ahead of 3");
    bus_wr(0, 8'h20);
    do_ack(8'h43, "R10 remaining level 3");
    bus_wr(0, 8'h20);
    bus_wr(0, 8'hC7);

    set_req(8'h00);
    do_ack(8'h47, "R7 no pending request returns level 7");
    bus_wr(0, 8'h0B);
    bus_rd(0, 8'h00, "R7 empty ack leaves in-service clear");

    // cascade path with fourth word, automatic end-of-interrupt, base 0x88
    bus_wr(1, 8'hF0);
    bus_wr(0, 8'h11);
    bus_rd(1, 8'h00, "R2 restart clears mask");
    bus_wr(1, 8'h88);
    bus_wr(1, 8'h00);
    bus_wr(1, 8'h02);
    bus_rd(1, 8'h00, "R3 extra cascade word not taken as mask");
    bus_rd(0, 8'h00, "R2 read source back to request register");
    set_req(8'h40);
    chk_irq(1, "R3 ready after cascade sequence");
    do_ack(8'h8E, "R3 R9 new base with input 6");
    bus_wr(0, 8'h0B);
    bus_rd(0, 8'h00, "R9 automatic end leaves in-service clear");
    chk_irq(0, "R9 irq low after automatic end");

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule